// File: doc/BRIEF.md
# CAN Bit Stuffer and Destuffer

This unit sits between a CAN frame engine and the transceiver pins and works one bit time at a time. A single-cycle bit strobe marks each bit time. The frame engine raises a region input while the current bits lie between start of frame and the end of the CRC sequence. Stuffing and destuffing happen only while that input is high.

In the transmit direction, the unit forwards frame bits to the TX pin. After five equal bits inside the region, it sends one bit of the opposite level. While that bit goes out it raises a stall, so the engine keeps its current bit for the next strobe. In the receive direction, it takes the sampled bus level and hands each data bit to the engine with a one-cycle valid pulse. After five equal bits, the next bit is dropped as a stuff bit. If that bit has the same level as the run, a stuff-error pulse is raised instead.

Both directions count an inserted or removed stuff bit as the first bit of a new run. The run count is cleared whenever the region input is low. A start-of-frame input makes the current bit the first bit of a fresh run. Level 0 is dominant and level 1 is recessive on both pins. All state changes only on a strobe, and reset is synchronous and active low.

Top module: `canBitStuffer`

## Requirements
- R1: While `stuffRegion` is 0, each strobe copies `txFrameBit` to `txPin` and `rxPin` to `rxBit` with `rxValid` high. `txStall` and `stuffErr` stay 0, however long a run of equal bits lasts.
- R2: Inside the region, if the five bits sent just before a strobe all have one level, then at that strobe `txStall` is 1 and `txPin` takes the opposite level. `txFrameBit` is not consumed at that strobe.
- R3: An inserted stuff bit counts as a run of one at its own level. Four more frame bits of that level therefore cause the next stuff bit.
- R4: Inside the region, after five equal received bits, an opposite-level bit on the next strobe is dropped: `rxValid` stays 0 and `stuffErr` stays 0. That bit starts a new run of one.
- R5: Inside the region, a sixth equal received bit gives a one-cycle `stuffErr` pulse with `rxValid` 0. The receive run then restarts at one at that level.
- R6: A strobe with `stuffRegion` 0 clears both run counts. After the region opens again, five more equal bits are needed before any stuffing.
- R7: A strobe with `frameStart` 1 inside the region treats its bit as the first bit of a new run in both directions. Earlier bits are ignored.
- R8: During and right after reset, `txPin` is 1 (recessive), `rxValid` and `stuffErr` are 0, and `txStall` is 0.
- R9: Without a strobe, `txPin` and `rxBit` hold their values. `rxValid` and `stuffErr` are 0 in every cycle that does not directly follow a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bitStrobe | input | 1 | One-cycle pulse per bit time |
| stuffRegion | input | 1 | High while the current bit lies in the stuffed part of the frame |
| frameStart | input | 1 | High on the start-of-frame bit strobe |
| txFrameBit | input | 1 | Next frame bit from the frame engine |
| txStall | output | 1 | High when the coming strobe sends a stuff bit; the engine holds its bit |
| txPin | output | 1 | Stuffed transmit level (0 dominant) |
| rxPin | input | 1 | Sampled receive level (0 dominant) |
| rxBit | output | 1 | Destuffed received bit |
| rxValid | output | 1 | One-cycle pulse when `rxBit` carries a data bit |
| stuffErr | output | 1 | One-cycle pulse on a sixth equal received bit |

## Verification
The main stream feeds the transmitted output back as receive input. Runs of zeros and runs of ones are used, so each stuff level is inserted and dropped. Chained runs, where a stuff bit starts the next run, separate "stuff bit counts as one" from "counter restarts at zero". A long run outside the region shows that stuffing is gated there. A region that reopens after an idle stretch, and a start of frame placed in the middle of a run, each tell apart a counter that was really reset from one that kept its old value. A sixth equal received bit separates a stuff error from a normal drop.

// File: rtl/canStuffPkg.sv
package canStuffPkg;
  typedef struct packed {
    logic txLoad;
    logic txBitVal;
    logic rxKeep;
    logic rxBitVal;
    logic rxErr;
  } stuffStrobes_t;
endpackage

// File: rtl/canRunTracker.sv
module canRunTracker #(
  parameter int RUN_LIMIT = 5,
  parameter int CNT_W = $clog2(RUN_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  input  logic             clear,
  input  logic             restart,
  input  logic             bitIn,
  output logic             runLevel,
  output logic [CNT_W-1:0] runCount
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCount <= '0;
      runLevel <= 1'b1;
    end else if (advance) begin
      if (clear) begin
        runCount <= '0;
      end else if (restart || runCount == '0 || bitIn != runLevel) begin
        runCount <= CNT_W'(1);
        runLevel <= bitIn;
      end else if (runCount < LIMIT) begin
        runCount <= runCount + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/canStuffCtrl.sv
module canStuffCtrl
  import canStuffPkg::*;
#(
  parameter int RUN_LIMIT = 5,
  parameter int CNT_W = $clog2(RUN_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitStrobe,
  input  logic          stuffRegion,
  input  logic          frameStart,
  input  logic          txFrameBit,
  input  logic          rxPin,
  output logic          txStall,
  output stuffStrobes_t strobes
);
  localparam int LANES = 2;
  localparam int TX_LANE = 0;
  localparam int RX_LANE = 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LIMIT);

  logic             laneBit     [LANES];
  logic             laneRestart [LANES];
  logic             laneLevel   [LANES];
  logic [CNT_W-1:0] laneCount   [LANES];
  logic             laneAtLimit [LANES];

  logic txBitOut;
  logic rxErrNow;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneAtLimit[g] = stuffRegion && !frameStart && (laneCount[g] == LIMIT);

    canRunTracker #(.RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)) u_run (
      .clk      (clk),
      .rstN     (rstN),
      .advance  (bitStrobe),
      .clear    (!stuffRegion),
      .restart  (laneRestart[g]),
      .bitIn    (laneBit[g]),
      .runLevel (laneLevel[g]),
      .runCount (laneCount[g])
    );
  end

  always_comb begin
    txBitOut = laneAtLimit[TX_LANE] ? ~laneLevel[TX_LANE] : txFrameBit;
    rxErrNow = laneAtLimit[RX_LANE] && (rxPin == laneLevel[RX_LANE]);

    laneBit[TX_LANE]     = txBitOut;
    laneRestart[TX_LANE] = frameStart;
    laneBit[RX_LANE]     = rxPin;
    laneRestart[RX_LANE] = frameStart || rxErrNow;

    txStall = laneAtLimit[TX_LANE];

    strobes.txLoad   = bitStrobe;
    strobes.txBitVal = txBitOut;
    strobes.rxKeep   = bitStrobe && !laneAtLimit[RX_LANE];
    strobes.rxBitVal = rxPin;
    strobes.rxErr    = bitStrobe && rxErrNow;
  end
endmodule

// File: rtl/canStuffDatapath.sv
module canStuffDatapath
  import canStuffPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  stuffStrobes_t strobes,
  output logic          txPin,
  output logic          rxBit,
  output logic          rxValid,
  output logic          stuffErr
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPin    <= 1'b1;
      rxBit    <= 1'b1;
      rxValid  <= 1'b0;
      stuffErr <= 1'b0;
    end else begin
      rxValid  <= strobes.rxKeep;
      stuffErr <= strobes.rxErr;
      if (strobes.txLoad) txPin <= strobes.txBitVal;
      if (strobes.rxKeep) rxBit <= strobes.rxBitVal;
    end
  end
endmodule

// File: rtl/canBitStuffer.sv
module canBitStuffer
  import canStuffPkg::*;
#(
  parameter int RUN_LIMIT = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitStrobe,
  input  logic stuffRegion,
  input  logic frameStart,
  input  logic txFrameBit,
  output logic txStall,
  output logic txPin,
  input  logic rxPin,
  output logic rxBit,
  output logic rxValid,
  output logic stuffErr
);
  localparam int CNT_W = $clog2(RUN_LIMIT + 1);

  stuffStrobes_t strobes;

  canStuffCtrl #(.RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .bitStrobe   (bitStrobe),
    .stuffRegion (stuffRegion),
    .frameStart  (frameStart),
    .txFrameBit  (txFrameBit),
    .rxPin       (rxPin),
    .txStall     (txStall),
    .strobes     (strobes)
  );

  canStuffDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .txPin    (txPin),
    .rxBit    (rxBit),
    .rxValid  (rxValid),
    .stuffErr (stuffErr)
  );
endmodule

// File: rtl/canBitStuffer_chk.sv
module canBitStuffer_chk (
  input logic clk,
  input logic rstN,
  input logic bitStrobe,
  input logic stuffRegion,
  input logic frameStart,
  input logic txFrameBit,
  input logic txStall,
  input logic txPin,
  input logic rxPin,
  input logic rxBit,
  input logic rxValid,
  input logic stuffErr
);
  // R1: pass-through outside the stuffed region
  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && !stuffRegion) |=> (txPin == $past(txFrameBit)) && rxValid && (rxBit == $past(rxPin)));

  assert_no_stall_outside_R1: assert property (@(posedge clk) disable iff (!rstN)
    !stuffRegion |-> !txStall);

  // R2: a stuff bit is the opposite of the last bit on the pin
  assert_stuff_flips_R2: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && txStall) |=> (txPin == !$past(txPin)));

  // R5: an error pulse never carries data
  assert_err_not_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    stuffErr |-> !rxValid);

  // R9: nothing moves without a strobe
  assert_hold_tx_R9: assert property (@(posedge clk) disable iff (!rstN)
    !bitStrobe |=> $stable(txPin) && !rxValid && !stuffErr);
endmodule

bind canBitStuffer canBitStuffer_chk u_chk (.*);

// File: tb/canBitStuffer_bench.sv
`timescale 1ns/1ps
module canBitStuffer_bench;
  logic clk = 1'b0;
  logic rstN, bitStrobe, stuffRegion, frameStart, txFrameBit, rxPin;
  logic txStall, txPin, rxBit, rxValid, stuffErr;

  int nChecks = 0;
  int nFails = 0;
  bit doneFlag = 0;

  always #2 clk = ~clk;

  canBitStuffer u_canBitStuffer (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .stuffRegion(stuffRegion),
    .frameStart(frameStart), .txFrameBit(txFrameBit), .txStall(txStall),
    .txPin(txPin), .rxPin(rxPin), .rxBit(rxBit), .rxValid(rxValid), .stuffErr(stuffErr)
  );

  // {tag[3:0], region, sof, txBit, rxIn, expTx, expStall, expValid, expErr}
  localparam logic [11:0] VEC [0:36] = '{
    {4'd2, 8'b1100_0010}, {4'd2, 8'b1000_0010}, {4'd2, 8'b1000_0010},
    {4'd2, 8'b1000_0010}, {4'd2, 8'b1000_0010}, {4'd2, 8'b1011_1100},
    {4'd3, 8'b1011_1010}, {4'd3, 8'b1011_1010}, {4'd3, 8'b1011_1010},
    {4'd3, 8'b1011_1010}, {4'd3, 8'b1000_0100}, {4'd3, 8'b1000_0010},
    {4'd5, 8'b1000_0010}, {4'd5, 8'b1000_0010}, {4'd5, 8'b1000_0010},
    {4'd5, 8'b1000_1101},
    {4'd1, 8'b0011_1010}, {4'd1, 8'b0011_1010}, {4'd1, 8'b0011_1010},
    {4'd1, 8'b0011_1010}, {4'd1, 8'b0011_1010}, {4'd1, 8'b0011_1010},
    {4'd6, 8'b1011_1010}, {4'd6, 8'b1011_1010}, {4'd6, 8'b1011_1010},
    {4'd6, 8'b1011_1010}, {4'd6, 8'b1011_1010}, {4'd4, 8'b1000_0100},
    {4'd7, 8'b1000_0010}, {4'd7, 8'b1000_0010}, {4'd7, 8'b1000_0010},
    {4'd7, 8'b1100_0010}, {4'd7, 8'b1000_0010}, {4'd7, 8'b1000_0010},
    {4'd7, 8'b1000_0010}, {4'd7, 8'b1000_0010}, {4'd7, 8'b1011_1100}
  };

  function automatic string reqName(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!doneFlag) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; bitStrobe = 1'b0; stuffRegion = 1'b0; frameStart = 1'b0;
    txFrameBit = 1'b0; rxPin = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "txPin in reset", txPin, 1'b1);
    check("R8", "rxValid in reset", rxValid, 1'b0);
    check("R8", "stuffErr in reset", stuffErr, 1'b0);
    check("R8", "txStall in reset", txStall, 1'b0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", "txPin after reset", txPin, 1'b1);
    check("R9", "txPin holds without strobe", txPin, 1'b1);
    check("R9", "rxValid idle without strobe", rxValid, 1'b0);

    bitStrobe = 1'b1;
    @(negedge clk);
    bitStrobe = 1'b0;
    check("R1", "txPin pass", txPin, 1'b0);
    check("R1", "rxValid pass", rxValid, 1'b1);
    check("R1", "rxBit pass", rxBit, 1'b0);
    txFrameBit = 1'b1; rxPin = 1'b1;
    @(negedge clk);
    check("R9", "rxValid single cycle", rxValid, 1'b0);
    check("R9", "txPin holds new input", txPin, 1'b0);
    check("R9", "rxBit holds", rxBit, 1'b0);

    for (int i = 0; i < 37; i++) begin
      string rq;
      rq = reqName(VEC[i][11:8]);
      stuffRegion = VEC[i][7];
      frameStart  = VEC[i][6];
      txFrameBit  = VEC[i][5];
      rxPin       = VEC[i][4];
      bitStrobe   = 1'b1;
      #1;
      check(rq, $sformatf("txStall vec %0d", i), txStall, VEC[i][2]);
      @(negedge clk);
      bitStrobe = 1'b0;
      frameStart = 1'b0;
      check(rq, $sformatf("txPin vec %0d", i), txPin, VEC[i][3]);
      check(rq, $sformatf("rxValid vec %0d", i), rxValid, VEC[i][1]);
      check(rq, $sformatf("stuffErr vec %0d", i), stuffErr, VEC[i][0]);
      if (VEC[i][1]) check(rq, $sformatf("rxBit vec %0d", i), rxBit, VEC[i][4]);
    end

    @(negedge clk);
    check("R5", "stuffErr single cycle", stuffErr, 1'b0);
    check("R9", "txPin holds after table", txPin, 1'b1);

    doneFlag = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule